// File: doc/BRIEF.md
# Receive Message Buffer with Trailing Status Byte

This block sits between a framed serial receiver (for example an HDLC deframer that has already removed flags, stuffing and the CRC field) and a host processor. The receiver hands over frame bytes one at a time, then either an end-of-frame marker with a CRC verdict or an abort. The bytes are stored in a 64-entry byte queue. When the frame finishes, one extra byte describing its outcome is written behind the last data byte. The host then sees a fill count that already includes that trailing byte.

While a frame is still arriving, a block-ready interrupt tells the host that a programmable number of bytes can be drained. A one-cycle data-request strobe accompanies it so that a DMA engine can do the draining instead. When the frame ends, a message-end interrupt is raised together with a one-cycle end strobe. The host acknowledges the finished message with a release command. That command frees whatever is left of the message and clears the interrupt. Only one completed message is held at a time, and the receiver side is ignored until it is released.

The trailing byte is laid out as `{mode[1:0], 1'b0, code[4:0]}`. The mode bits are copied from a configuration input. The code says how the frame ended: good, CRC failure, overflow or abort.

Top module: `rxmsg_fifo`

## Requirements
- R1: After reset the fill count is 0 and `irq_pool_o`, `irq_end_o`, `dma_req_o` and `dma_end_o` are all 0.
- R2: Each accepted byte (`rx_valid_i` high, no end or abort that cycle) raises `fill_o` by one on the next clock edge. Bytes come out on `rd_data_o` in arrival order, one per cycle with `rd_en_i` high.
- R3: On `rx_end_i`, one status byte `{smode_i, 1'b0, code}` is stored after the last data byte and counted in `fill_o`. The code is 5'b00000 when `rx_crc_ok_i` is 1 and 5'b00001 when it is 0.
- R4: The clock edge that stores the status byte sets `irq_end_o` and pulses `dma_end_o` high for exactly one cycle. `irq_end_o` then stays high until it is acknowledged.
- R5: On `rx_abort_i`, the frame is closed the same way as in R4, with status code 5'b00100.
- R6: A data byte is stored only while `fill_o` is below 63, so one slot stays free for the status byte. A byte that finds no room is dropped, every later byte of that frame is dropped, and the frame's status code becomes 5'b00011. `fill_o` never exceeds 64.
- R7: While no message is pending, `irq_pool_o` rises on the edge at which `fill_o` reaches the threshold of 4 << `thr_sel_i` (0→4, 1→8, 2→16, 3→32). `dma_req_o` pulses high for that one cycle.
- R8: `irq_pool_o` falls on the edge of the threshold-th read after it rose. It also falls when the frame is closed (R4, R5).
- R9: `ack_i` while `irq_end_o` is high empties the queue (`fill_o` becomes 0) and clears `irq_end_o` on the next edge. `ack_i` with no pending message has no effect.
- R10: While `irq_end_o` is high, `rx_valid_i`, `rx_end_i` and `rx_abort_i` are ignored.
- R11: `rd_en_i` with an empty queue has no effect; `fill_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smode_i | input | 2 | Mode bits copied into the status byte |
| thr_sel_i | input | 2 | Block-ready threshold select (4 << value) |
| rx_valid_i | input | 1 | Receiver presents a data byte |
| rx_byte_i | input | 8 | Data byte from the receiver |
| rx_end_i | input | 1 | Frame finished |
| rx_crc_ok_i | input | 1 | CRC verdict, sampled with `rx_end_i` |
| rx_abort_i | input | 1 | Frame aborted |
| rd_en_i | input | 1 | Host or DMA pops the head byte |
| rd_data_o | output | 8 | Head byte of the queue |
| ack_i | input | 1 | Release command for the completed message |
| fill_o | output | 7 | Number of stored bytes, status byte included |
| irq_pool_o | output | 1 | Block-ready interrupt |
| irq_end_o | output | 1 | Message-end interrupt |
| dma_req_o | output | 1 | One-cycle data-request strobe |
| dma_end_o | output | 1 | One-cycle message-end strobe |

## Verification
The bench fills the queue past capacity. A design that lets a data byte take the last slot would report a count of 65, or would lose the status byte. It checks the block-ready flag one byte before and exactly at the 4-byte and 32-byte thresholds, and one read before and exactly at the clearing read, so an off-by-one compare shows up as a flag that rises or falls a cycle early. It feeds bytes, ends and aborts into a pending message, and sends a release with nothing pending, because a design without those guards would corrupt the stored count. All four status codes are read back with a non-zero mode field, which catches a wrong bit position or a mode field that is never inserted.

// File: rtl/rxmsg_pkg.sv
package rxmsg_pkg;

    // Outcome codes carried in bits 4:0 of the trailing status byte.
    typedef enum logic [4:0] {
        ST_GOOD   = 5'b00000,
        ST_BADCRC = 5'b00001,
        ST_FLAG   = 5'b00010,
        ST_OVF    = 5'b00011,
        ST_ABORT  = 5'b00100
    } stat_code_e;

endpackage

// File: rtl/rxmsg_stat_fmt.sv
module rxmsg_stat_fmt
    import rxmsg_pkg::*;
(
    input  logic [1:0]  mode_i,
    input  stat_code_e  code_i,
    output logic [7:0]  stat_o
);
    // Bit 5 is reserved and always zero.
    assign stat_o = {mode_i, 1'b0, code_i};
endmodule

// File: rtl/rxmsg_store.sv
module rxmsg_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxmsg_fifo.sv
module rxmsg_fifo
    import rxmsg_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int THR_MIN = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int FW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    smode_i,
    input  logic [1:0]    thr_sel_i,
    input  logic          rx_valid_i,
    input  logic [7:0]    rx_byte_i,
    input  logic          rx_end_i,
    input  logic          rx_crc_ok_i,
    input  logic          rx_abort_i,
    input  logic          rd_en_i,
    output logic [7:0]    rd_data_o,
    input  logic          ack_i,
    output logic [FW-1:0] fill_o,
    output logic          irq_pool_o,
    output logic          irq_end_o,
    output logic          dma_req_o,
    output logic          dma_end_o
);
    localparam logic [FW-1:0] DATA_MAX = FW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [FW-1:0] fill;
        logic [FW-1:0] rd_cnt;
        logic          ovf;
        logic          end_pend;
        logic          pool;
        logic          dma_req;
        logic          dma_end;
    } state_t;

    state_t        q, d;
    stat_code_e    code;
    logic [7:0]    stat_byte;
    logic [7:0]    wdata;
    logic          we;
    logic          close;
    logic          pop;
    logic [FW-1:0] thr;

    assign thr = FW'(THR_MIN) << thr_sel_i;

    // Outcome of the frame being closed this cycle.
    always_comb begin
        if (rx_abort_i)       code = ST_ABORT;
        else if (q.ovf)       code = ST_OVF;
        else if (rx_crc_ok_i) code = ST_GOOD;
        else                  code = ST_BADCRC;
    end

    rxmsg_stat_fmt u_fmt (
        .mode_i (smode_i),
        .code_i (code),
        .stat_o (stat_byte)
    );

    always_comb begin
        d         = q;
        d.dma_req = 1'b0;
        d.dma_end = 1'b0;
        we        = 1'b0;
        close     = 1'b0;

        // Receiver side: abort beats end beats data; all held off while pending.
        if (!q.end_pend) begin
            if (rx_abort_i || rx_end_i) begin
                we    = 1'b1;
                close = 1'b1;
            end else if (rx_valid_i) begin
                if (q.ovf || q.fill >= DATA_MAX) d.ovf = 1'b1;
                else                              we    = 1'b1;
            end
        end
        wdata = close ? stat_byte : rx_byte_i;

        pop = rd_en_i && (q.fill != '0) && !(ack_i && q.end_pend);

        if (we)  d.wr_ptr = q.wr_ptr + 1'b1;
        if (pop) d.rd_ptr = q.rd_ptr + 1'b1;
        d.fill = q.fill + FW'(we) - FW'(pop);

        // Block-ready interrupt and data-request strobe.
        if (close) begin
            d.ovf      = 1'b0;
            d.end_pend = 1'b1;
            d.dma_end  = 1'b1;
            d.pool     = 1'b0;
            d.rd_cnt   = '0;
        end else if (q.pool) begin
            if (pop) begin
                if (q.rd_cnt + 1'b1 == thr) begin
                    d.pool   = 1'b0;
                    d.rd_cnt = '0;
                end else begin
                    d.rd_cnt = q.rd_cnt + 1'b1;
                end
            end
        end else if (!q.end_pend && d.fill >= thr) begin
            d.pool    = 1'b1;
            d.dma_req = 1'b1;
        end

        // Release of the completed message.
        if (ack_i && q.end_pend) begin
            d.end_pend = 1'b0;
            d.rd_ptr   = q.wr_ptr;
            d.fill     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    rxmsg_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (q.wr_ptr),
        .wdata_i (wdata),
        .raddr_i (q.rd_ptr),
        .rdata_o (rd_data_o)
    );

    assign fill_o     = q.fill;
    assign irq_pool_o = q.pool;
    assign irq_end_o  = q.end_pend;
    assign dma_req_o  = q.dma_req;
    assign dma_end_o  = q.dma_end;
endmodule

// File: rtl/rxmsg_fifo_chk.sv
module rxmsg_fifo_chk #(
    parameter int FW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid_i,
    input logic          rx_end_i,
    input logic          rx_abort_i,
    input logic          rd_en_i,
    input logic          ack_i,
    input logic [FW-1:0] fill_o,
    input logic          irq_pool_o,
    input logic          irq_end_o,
    input logic          dma_req_o,
    input logic          dma_end_o
);
    localparam logic [FW-1:0] CAP = FW'(1) << (FW - 1);

    p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= CAP);

    p_end_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_end_o |=> !dma_end_o);

    p_end_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_end_o |-> irq_end_o);

    p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> irq_pool_o);

    p_req_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |=> !dma_req_o);

    p_pool_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_end_o |-> !irq_pool_o);

    p_ack_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_end_o) |=> (fill_o == '0) && !irq_end_o);

    p_pending_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_end_o && !ack_i && !rd_en_i && (rx_valid_i || rx_end_i || rx_abort_i))
        |=> $stable(fill_o) && irq_end_o);

    p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o == '0 && rd_en_i && !rx_valid_i && !rx_end_i && !rx_abort_i)
        |=> fill_o == '0);
endmodule

bind rxmsg_fifo rxmsg_fifo_chk #(.FW(FW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid_i (rx_valid_i),
    .rx_end_i   (rx_end_i),
    .rx_abort_i (rx_abort_i),
    .rd_en_i    (rd_en_i),
    .ack_i      (ack_i),
    .fill_o     (fill_o),
    .irq_pool_o (irq_pool_o),
    .irq_end_o  (irq_end_o),
    .dma_req_o  (dma_req_o),
    .dma_end_o  (dma_end_o)
);

// File: tb/rxmsg_fifo_tb.sv
module rxmsg_fifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] smode = 2'b10;
    logic [1:0] thr_sel = 2'd1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_end = 1'b0;
    logic       rx_crc_ok = 1'b0;
    logic       rx_abort = 1'b0;
    logic       rd_en = 1'b0;
    logic       ack = 1'b0;
    logic [7:0] rd_data;
    logic [6:0] fill;
    logic       irq_pool, irq_end, dma_req, dma_end;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rxmsg_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .smode_i(smode), .thr_sel_i(thr_sel),
        .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .rx_end_i(rx_end),
        .rx_crc_ok_i(rx_crc_ok), .rx_abort_i(rx_abort), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .ack_i(ack), .fill_o(fill),
        .irq_pool_o(irq_pool), .irq_end_o(irq_end),
        .dma_req_o(dma_req), .dma_end_o(dma_end)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic finish_frame(input logic ok);
        @(negedge clk); rx_end = 1'b1; rx_crc_ok = ok;
        @(negedge clk); rx_end = 1'b0;
    endtask

    task automatic abort_frame();
        @(negedge clk); rx_abort = 1'b1;
        @(negedge clk); rx_abort = 1'b0;
    endtask

    task automatic pop_chk(input string tag, input int exp);
        @(negedge clk);
        chk(tag, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic release_msg();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 fill", fill, 0);
        chk("R1 irq_pool", irq_pool, 0);
        chk("R1 irq_end", irq_end, 0);
        chk("R1 dma strobes", {dma_req, dma_end}, 0);
    endtask

    task automatic t_good_frame();
        thr_sel = 2'd1;
        for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
        chk("R2 fill after bytes", fill, 5);
        finish_frame(1'b1);
        chk("R3 fill includes status", fill, 6);
        chk("R4 irq_end", irq_end, 1);
        chk("R4 dma_end pulse", dma_end, 1);
        @(negedge clk);
        chk("R4 dma_end one cycle", dma_end, 0);
        chk("R4 irq_end held", irq_end, 1);
        push(8'hEE);
        finish_frame(1'b0);
        abort_frame();
        chk("R10 pending ignores rx", fill, 6);
        for (int i = 0; i < 5; i++) pop_chk("R2 order", 8'h10 + i);
        pop_chk("R3 good status", 8'h80);
        release_msg();
        chk("R9 irq_end cleared", irq_end, 0);
        chk("R9 fill emptied", fill, 0);
    endtask

    task automatic t_crc_fail();
        for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i));
        release_msg();
        chk("R9 ack ignored when idle", fill, 3);
        finish_frame(1'b0);
        chk("R3 fill crc frame", fill, 4);
        for (int i = 0; i < 3; i++) pop_chk("R2 order crc", 8'hA0 + i);
        pop_chk("R3 crc status", 8'h81);
        release_msg();
    endtask

    task automatic t_unread_release();
        for (int i = 0; i < 6; i++) push(8'h50 + 8'(i));
        finish_frame(1'b1);
        chk("R3 fill before flush", fill, 7);
        release_msg();
        chk("R9 flush unread", fill, 0);
        push(8'h77);
        pop_chk("R9 fresh data after flush", 8'h77);
        finish_frame(1'b1);
        release_msg();
    endtask

    task automatic t_threshold();
        thr_sel = 2'd0;
        for (int i = 0; i < 3; i++) push(8'(i));
        chk("R7 below threshold", irq_pool, 0);
        push(8'd3);
        chk("R7 pool at 4", irq_pool, 1);
        chk("R7 dma_req with pool", dma_req, 1);
        @(negedge clk);
        chk("R7 dma_req one cycle", dma_req, 0);
        for (int i = 0; i < 3; i++) pop_chk("R2 order thr", i);
        chk("R8 held before 4th read", irq_pool, 1);
        pop_chk("R2 order thr", 3);
        chk("R8 cleared at 4th read", irq_pool, 0);
        for (int i = 0; i < 5; i++) push(8'h20 + 8'(i));
        chk("R7 pool again", irq_pool, 1);
        finish_frame(1'b1);
        chk("R8 cleared at end", irq_pool, 0);
        release_msg();
        thr_sel = 2'd3;
        for (int i = 0; i < 31; i++) push(8'(i));
        chk("R7 below 32", irq_pool, 0);
        push(8'd31);
        chk("R7 pool at 32", irq_pool, 1);
        chk("R7 dma_req at 32", dma_req, 1);
        abort_frame();
        chk("R5 fill with abort status", fill, 33);
        chk("R8 abort clears pool", irq_pool, 0);
        release_msg();
    endtask

    task automatic t_abort();
        push(8'hC1);
        push(8'hC2);
        abort_frame();
        chk("R5 fill", fill, 3);
        chk("R5 irq_end", irq_end, 1);
        pop_chk("R5 data", 8'hC1);
        pop_chk("R5 data", 8'hC2);
        pop_chk("R5 abort status", 8'h84);
        release_msg();
    endtask

    task automatic t_overflow();
        thr_sel = 2'd3;
        for (int i = 0; i < 70; i++) push(8'(i));
        chk("R6 fill capped at 63", fill, 63);
        finish_frame(1'b1);
        chk("R6 fill with status", fill, 64);
        for (int i = 0; i < 63; i++) pop_chk("R6 kept bytes", i);
        pop_chk("R6 overflow status", 8'h83);
        release_msg();
    endtask

    task automatic t_empty_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk("R11 empty read", fill, 0);
        push(8'h3C);
        chk("R11 fill after empty read", fill, 1);
        pop_chk("R11 data intact", 8'h3C);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_good_frame();
        t_crc_fail();
        t_unread_release();
        t_threshold();
        t_abort();
        t_overflow();
        t_empty_read();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule